// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register File

This block holds the software-visible control and status state of one bus-master disk DMA channel. Software reaches it through a small word-addressed register bus with byte enables. Through that bus it loads the physical base address of the descriptor table, sets the transfer direction, and starts or stops the channel. It also inspects and acknowledges the channel's status. The descriptor fetch engine and the drive-side timing sit outside the block. They exchange single-cycle strobes with it: a go pulse and a halt pulse leave the block, and end-of-table, engine-error and device-interrupt strobes enter it.

The status byte combines three kinds of bits. An active flag follows the engine handshakes. Error and interrupt flags latch engine events and are cleared by writing a one. Two plain read/write flags mark drive 0 and drive 1 as DMA-capable. Two more bits mirror an external read-only status input. An interrupt request output follows the interrupt flag. When software stops the channel, the block evaluates the status held at that moment and issues a one-cycle report. A transfer counts as clean only when the interrupt flag is set and both active and error are clear. Otherwise the report carries a failure code.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every register is zero: reads of all words return 0, and eng_run_o, eng_to_mem_o, eng_go_o, eng_halt_o, irq_o, rep_vld_o and desc_base_o are 0.
- R2: Word addresses select the registers: 0 = command, 1 = status, 2 = descriptor pointer. Word 3 reads 0 and ignores writes. A read request returns its data on reg_rdata_o in the cycle after the request.
- R3: Writing command bit 0 = 1 while stopped sets eng_run_o and pulses eng_go_o for exactly one cycle. Writing it as 1 while running gives no pulse. Writing it as 0 while running clears eng_run_o and pulses eng_halt_o for one cycle.
- R4: Command bit 3 is the direction flag and drives eng_to_mem_o: 1 means the device writes to memory, 0 means memory goes to the device. The command register is written only when byte enable 0 is set.
- R5: Status bit 0 (active) sets on a start that pulses eng_go_o and clears on eng_eot_i or eng_err_i. A start write in the same cycle as such a strobe leaves it set.
- R6: Status bit 1 (error) sets on eng_err_i and status bit 2 (interrupt) sets on dev_irq_i. Writing 1 to either bit clears it, and writing 0 leaves it unchanged. A strobe in the same cycle as a clearing write leaves the flag set.
- R7: Status bits 5 and 6 are read/write DMA-capable flags for drive 0 and drive 1. Writes to bits 0, 3, 4 and 7 have no effect.
- R8: Status bits 3 and 4 read the current value of stat_aux_i[1:0], and bit 7 reads 0.
- R9: The descriptor pointer is written per byte lane under reg_be_i. Bits 1:0 always read 0, and desc_base_o carries the stored value.
- R10: irq_o is high exactly while the status interrupt flag is set.
- R11: In the cycle after a write that stops the channel, rep_vld_o is high for one cycle. rep_ok_o is 1 and rep_code_o is 0 when status bits 2:0 equalled 3'b100 at the stop write. Otherwise rep_ok_o is 0 and rep_code_o is that status byte with bit 4 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Word address |
| reg_be_i | input | 4 | Byte enables for writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| eng_go_o | output | 1 | One-cycle start pulse to the engine |
| eng_halt_o | output | 1 | One-cycle stop pulse to the engine |
| eng_run_o | output | 1 | Command start bit |
| eng_to_mem_o | output | 1 | Direction: device to memory |
| desc_base_o | output | 32 | Descriptor table base address |
| eng_eot_i | input | 1 | Engine end-of-table strobe |
| eng_err_i | input | 1 | Engine error strobe |
| dev_irq_i | input | 1 | Device interrupt strobe |
| stat_aux_i | input | 2 | Read-only status bits 3 and 4 |
| irq_o | output | 1 | Interrupt request |
| rep_vld_o | output | 1 | Completion report valid |
| rep_ok_o | output | 1 | Transfer ended cleanly |
| rep_code_o | output | 8 | 0 on success, status with bit 4 set on failure |

## Verification
Every register, the engine pulses and the completion report update on the clock edge that samples the write or strobe. The bench therefore drives stimulus at a falling edge and checks eng_go_o, eng_halt_o, irq_o and the rep_* outputs at the next falling edge, which is one cycle later. Read data is registered, so each read samples reg_rdata_o one falling edge after the request. The bench also reads back status after every strobe. Single-cycle pulses are checked once more a cycle later to confirm they have dropped.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_DIR_BIT = 3;

  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_INT  = 2;
  localparam int ST_AUX0 = 3;
  localparam int ST_CAP0 = 5;

  localparam logic [2:0] ST_CLEAN  = 3'b100;
  localparam logic [7:0] FAIL_MARK = 8'h10;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic go_bit_i,
  input  logic dir_bit_i,
  output logic run_o,
  output logic to_mem_o,
  output logic go_now_o,
  output logic halt_now_o,
  output logic go_o,
  output logic halt_o
);
  logic run_q, dir_q, go_q, halt_q;

  assign go_now_o   = wr_en_i & go_bit_i & ~run_q;
  assign halt_now_o = wr_en_i & ~go_bit_i & run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      go_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      go_q   <= go_now_o;
      halt_q <= halt_now_o;
      if (wr_en_i) begin
        run_q <= go_bit_i;
        dir_q <= dir_bit_i;
      end
    end
  end

  assign run_o    = run_q;
  assign to_mem_o = dir_q;
  assign go_o     = go_q;
  assign halt_o   = halt_q;
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg #(
  parameter int N_DRV  = 2,
  parameter int AUX_W  = 2,
  localparam int STAT_W = 3 + AUX_W + N_DRV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              clr_err_i,
  input  logic              clr_int_i,
  input  logic [N_DRV-1:0]  cap_wdata_i,
  input  logic              go_i,
  input  logic              eot_i,
  input  logic              err_i,
  input  logic              irq_i,
  input  logic [AUX_W-1:0]  aux_i,
  output logic [STAT_W-1:0] stat_o
);
  logic act_q, err_q, int_q;
  logic [N_DRV-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      // a new start outranks a finishing strobe
      if (go_i)               act_q <= 1'b1;
      else if (eot_i | err_i) act_q <= 1'b0;
      // event strobes outrank write-one-to-clear
      err_q <= (err_q & ~(wr_en_i & clr_err_i)) | err_i;
      int_q <= (int_q & ~(wr_en_i & clr_int_i)) | irq_i;
    end
  end

  for (genvar d = 0; d < N_DRV; d++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cap_q[d] <= 1'b0;
      else if (wr_en_i) cap_q[d] <= cap_wdata_i[d];
    end
  end

  assign stat_o = {cap_q, aux_i, int_q, err_q, act_q};
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int PTR_W  = 32,
  parameter int ALIGN  = 2,
  localparam int LANES = PTR_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [LANES-1:0] be_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  ptr_q[l*8 +: 8] <= 8'h00;
      else if (wr_en_i && be_i[l])  ptr_q[l*8 +: 8] <= wdata_i[l*8 +: 8];
    end
  end

  assign ptr_o = {ptr_q[PTR_W-1:ALIGN], {ALIGN{1'b0}}};
endmodule

// File: rtl/bmdma_done_eval.sv
module bmdma_done_eval #(
  parameter int STAT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_now_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              vld_o,
  output logic              ok_o,
  output logic [7:0]        code_o
);
  import bmdma_pkg::*;

  logic [7:0] stat_b;
  logic       clean;
  logic       vld_q, ok_q;
  logic [7:0] code_q;

  assign stat_b = {{(8-STAT_W){1'b0}}, stat_i};
  assign clean  = (stat_b[2:0] == ST_CLEAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      ok_q   <= 1'b0;
      code_q <= 8'h00;
    end else begin
      vld_q <= halt_now_i;
      if (halt_now_i) begin
        ok_q   <= clean;
        code_q <= clean ? 8'h00 : (stat_b | FAIL_MARK);
      end
    end
  end

  assign vld_o  = vld_q;
  assign ok_o   = ok_q;
  assign code_o = code_q;
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int ADDR_W = 2,
  parameter int N_DRV  = 2,
  parameter int AUX_W  = 2,
  localparam int DATA_W = 32,
  localparam int BE_W   = DATA_W / 8,
  localparam int STAT_W = 3 + AUX_W + N_DRV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BE_W-1:0]   reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              eng_go_o,
  output logic              eng_halt_o,
  output logic              eng_run_o,
  output logic              eng_to_mem_o,
  output logic [DATA_W-1:0] desc_base_o,
  input  logic              eng_eot_i,
  input  logic              eng_err_i,
  input  logic              dev_irq_i,
  input  logic [AUX_W-1:0]  stat_aux_i,
  output logic              irq_o,
  output logic              rep_vld_o,
  output logic              rep_ok_o,
  output logic [7:0]        rep_code_o
);
  import bmdma_pkg::*;

  reg_sel_e          sel;
  logic              in_range;
  logic              wr, rd;
  logic              wr_cmd, wr_stat, wr_ptr;
  logic              go_now, halt_now;
  logic [STAT_W-1:0] stat_w;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign in_range = ((reg_addr_i >> 2) == '0);
  assign sel      = reg_sel_e'(reg_addr_i[1:0]);
  assign wr       = reg_req_i & reg_we_i & in_range;
  assign rd       = reg_req_i & ~reg_we_i;

  assign wr_cmd  = wr & (sel == SEL_CMD)  & reg_be_i[0];
  assign wr_stat = wr & (sel == SEL_STAT) & reg_be_i[0];
  assign wr_ptr  = wr & (sel == SEL_PTR);

  bmdma_cmd_reg u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_cmd),
    .go_bit_i   (reg_wdata_i[CMD_GO_BIT]),
    .dir_bit_i  (reg_wdata_i[CMD_DIR_BIT]),
    .run_o      (eng_run_o),
    .to_mem_o   (eng_to_mem_o),
    .go_now_o   (go_now),
    .halt_now_o (halt_now),
    .go_o       (eng_go_o),
    .halt_o     (eng_halt_o)
  );

  bmdma_stat_reg #(.N_DRV(N_DRV), .AUX_W(AUX_W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_stat),
    .clr_err_i   (reg_wdata_i[ST_ERR]),
    .clr_int_i   (reg_wdata_i[ST_INT]),
    .cap_wdata_i (reg_wdata_i[ST_CAP0 +: N_DRV]),
    .go_i        (go_now),
    .eot_i       (eng_eot_i),
    .err_i       (eng_err_i),
    .irq_i       (dev_irq_i),
    .aux_i       (stat_aux_i),
    .stat_o      (stat_w)
  );

  bmdma_ptr_reg #(.PTR_W(DATA_W), .ALIGN(2)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_ptr),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i),
    .ptr_o   (desc_base_o)
  );

  bmdma_done_eval #(.STAT_W(STAT_W)) u_done (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_now_i (halt_now),
    .stat_i     (stat_w),
    .vld_o      (rep_vld_o),
    .ok_o       (rep_ok_o),
    .code_o     (rep_code_o)
  );

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      unique case (sel)
        SEL_CMD: begin
          rd_mux[CMD_GO_BIT]  = eng_run_o;
          rd_mux[CMD_DIR_BIT] = eng_to_mem_o;
        end
        SEL_STAT: rd_mux[STAT_W-1:0] = stat_w;
        SEL_PTR:  rd_mux = desc_base_o;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = stat_w[ST_INT];
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int STAT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eng_go_o,
  input logic              eng_halt_o,
  input logic              eng_run_o,
  input logic              eng_err_i,
  input logic              dev_irq_i,
  input logic              irq_o,
  input logic              rep_vld_o,
  input logic [STAT_W-1:0] stat_i
);
  p_go_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_go_o |=> !eng_go_o);

  p_go_runs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_go_o |-> eng_run_o);

  p_halt_stops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_halt_o |-> !eng_run_o);

  p_active_from_go_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[0]) |-> eng_go_o);

  p_err_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_i |=> stat_i[1]);

  p_irq_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_irq_i |=> irq_o);

  p_report_after_halt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_vld_o |-> eng_halt_o);
endmodule

bind bmdma_regs bmdma_regs_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eng_go_o   (eng_go_o),
  .eng_halt_o (eng_halt_o),
  .eng_run_o  (eng_run_o),
  .eng_err_i  (eng_err_i),
  .dev_irq_i  (dev_irq_i),
  .irq_o      (irq_o),
  .rep_vld_o  (rep_vld_o),
  .stat_i     (stat_w)
);

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        go, halt, run, to_mem, irq, rvld, rok;
  logic [31:0] base;
  logic [7:0]  rcode;
  logic        eot = 1'b0, err = 1'b0, dirq = 1'b0;
  logic [1:0]  aux = '0;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  bmdma_regs uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eng_go_o(go), .eng_halt_o(halt), .eng_run_o(run), .eng_to_mem_o(to_mem),
    .desc_base_o(base), .eng_eot_i(eot), .eng_err_i(err), .dev_irq_i(dirq),
    .stat_aux_i(aux), .irq_o(irq), .rep_vld_o(rvld), .rep_ok_o(rok),
    .rep_code_o(rcode)
  );

  // vector: {write, addr, be, data}; for reads data is the expected value
  localparam int NV = 14;
  localparam logic [38:0] VECS [NV] = '{
    {1'b1, 2'd2, 4'hF, 32'hDEADBEEF},
    {1'b0, 2'd2, 4'h0, 32'hDEADBEEC},
    {1'b1, 2'd2, 4'h4, 32'h00550000},
    {1'b0, 2'd2, 4'h0, 32'hDE55BEEC},
    {1'b1, 2'd0, 4'h1, 32'h00000008},
    {1'b0, 2'd0, 4'h0, 32'h00000008},
    {1'b1, 2'd1, 4'h1, 32'h000000FF},
    {1'b0, 2'd1, 4'h0, 32'h00000060},
    {1'b1, 2'd1, 4'h1, 32'h00000020},
    {1'b0, 2'd1, 4'h0, 32'h00000020},
    {1'b1, 2'd3, 4'hF, 32'hFFFFFFFF},
    {1'b0, 2'd3, 4'h0, 32'h00000000},
    {1'b1, 2'd0, 4'hE, 32'hFFFFFFFF},
    {1'b0, 2'd0, 4'h0, 32'h00000008}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    if (which == 0) eot = 1'b1;
    else if (which == 1) err = 1'b1;
    else dirq = 1'b1;
    @(negedge clk);
    eot = 1'b0; err = 1'b0; dirq = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 reset outputs", {25'd0, run, to_mem, go, halt, irq, rvld, 1'b0}, 32'h0);
    check("R1 reset base", base, 32'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [38:0] e;
      string tag;
      e = VECS[i];
      case (e[37:36])
        2'd0: tag = "R4 cmd vec";
        2'd1: tag = "R7 stat vec";
        2'd2: tag = "R9 ptr vec";
        default: tag = "R2 unmapped vec";
      endcase
      if (e[38]) wr_reg(e[37:36], e[35:32], e[31:0]);
      else begin
        rd_reg(e[37:36], v);
        check(tag, v, e[31:0]);
      end
    end
    check("R9 desc_base_o", base, 32'hDE55BEEC);
    check("R4 to_mem", {31'd0, to_mem}, 32'd1);

    // R8 aux bits
    aux = 2'b11;
    rd_reg(2'd1, v);
    check("R8 aux status", v, 32'h38);
    aux = 2'b00;

    // R3 start
    wr_reg(2'd0, 4'h1, 32'h09);
    check("R3 go pulse", {30'd0, go, run}, 32'd3);
    check("R3 no halt", {31'd0, halt}, 32'd0);
    @(negedge clk);
    check("R3 go single", {31'd0, go}, 32'd0);
    rd_reg(2'd1, v);
    check("R5 active set", v, 32'h21);
    wr_reg(2'd0, 4'h1, 32'h09);
    check("R3 no repeat go", {31'd0, go}, 32'd0);

    // R5 end of table
    strobe(0);
    rd_reg(2'd1, v);
    check("R5 active cleared by eot", v, 32'h20);

    // R10 interrupt
    strobe(2);
    check("R10 irq set", {31'd0, irq}, 32'd1);
    rd_reg(2'd1, v);
    check("R6 intr flag", v, 32'h24);

    // R11 clean stop
    wr_reg(2'd0, 4'h1, 32'h08);
    check("R3 halt pulse", {30'd0, halt, run}, 32'd2);
    check("R11 good report", {22'd0, rvld, rok, rcode}, {22'd0, 1'b1, 1'b1, 8'h00});
    @(negedge clk);
    check("R11 report single", {31'd0, rvld}, 32'd0);

    // R6 write-one-to-clear
    wr_reg(2'd1, 4'h1, 32'h24);
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    rd_reg(2'd1, v);
    check("R6 intr cleared", v, 32'h20);
    strobe(1);
    rd_reg(2'd1, v);
    check("R6 err set", v, 32'h22);
    wr_reg(2'd1, 4'h1, 32'h20);
    rd_reg(2'd1, v);
    check("R6 write zero kept", v, 32'h22);
    wr_reg(2'd1, 4'h1, 32'h22);
    rd_reg(2'd1, v);
    check("R6 err cleared", v, 32'h20);

    // R11 failed transfer
    wr_reg(2'd0, 4'h1, 32'h01);
    check("R4 to_mem clear", {31'd0, to_mem}, 32'd0);
    strobe(1);
    rd_reg(2'd1, v);
    check("R5 active cleared by err", v, 32'h22);
    wr_reg(2'd0, 4'h1, 32'h00);
    check("R11 bad report", {22'd0, rvld, rok, rcode}, {22'd0, 1'b1, 1'b0, 8'h32});

    // R6 strobe outranks clear
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 2'd1; be = 4'h1; wdata = 32'h22; err = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; err = 1'b0;
    rd_reg(2'd1, v);
    check("R6 strobe wins", v, 32'h22);
    wr_reg(2'd1, 4'h1, 32'h22);

    // R5 start outranks eot
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 2'd0; be = 4'h1; wdata = 32'h01; eot = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; eot = 1'b0;
    rd_reg(2'd1, v);
    check("R5 start wins", v, 32'h21);
    wr_reg(2'd0, 4'h1, 32'h00);
    check("R11 active report", {22'd0, rvld, rok, rcode}, {22'd0, 1'b1, 1'b0, 8'h31});

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule